// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that begins counting as soon as reset is released. A prescaler divides the clock by a programmable amount. Each prescaler tick lowers a 16-bit count by one. When the count runs out for the first time, the block pulses a high-priority interrupt line. It then reloads the count with a separate grace value and marks itself as armed. If software rewrites the program register before the grace count also runs out, the armed mark clears and the watchdog starts over. If software does not, the block pulses a system reset request, latches a fixed reset-cause code, and halts until something restarts it.

Software can switch the watchdog off through a second write-only register, the trap door. A trap-door write is honoured only while the block is still in its post-reset state, before it has ever been programmed. Once the switch-off is accepted, the block stops at the next prescaler tick. Any program-register write, in any state, reloads every field and sets the watchdog running. The system reset generator that acts on the request lies outside this block.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, `irq_o` and `rst_req_o` are low, `cause_o` is zero, and the block is counting with the reset-value fields: count `RST_COUNT`, scaler `RST_SCALER`, grace `RST_DELAY`.
- R2: A write with `wr_sel`=0 targets the program register. Its data word carries the count in bits 15:0, the scaler in bits 23:16 and the grace value in bits 31:24.
- R3: The count falls by one every (scaler+1) clocks. A program write restarts the prescaler phase, so the first tick after the write falls scaler+1 clocks later.
- R4: A tick that finds the count at zero while the block is not armed drives `irq_o` high for exactly one clock, sets the armed mark, and loads the count with the grace value.
- R5: A tick that finds the count at zero while the block is armed drives `rst_req_o` high for exactly one clock, sets `cause_o` to 0xC000, and halts the watchdog.
- R6: `cause_o` keeps its value until `rst_n` is asserted.
- R7: A program write clears the armed mark, reloads every field and puts the watchdog in the running state. This also applies from the halted state, and the write takes precedence over a tick in the same clock.
- R8: A write with `wr_sel`=1 (trap door) switches the watchdog off only if the block is still in its post-reset state. In any other state the write has no effect.
- R9: A switched-off watchdog becomes halted at its next tick. A halted watchdog produces no interrupt and no reset request until it is programmed again.
- R10: `irq_o` and `rst_req_o` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 program register, 1 trap door |
| wr_data | input | 32 | Write data |
| irq_o | output | 1 | One-clock interrupt pulse on first expiry |
| rst_req_o | output | 1 | One-clock system reset request on second expiry |
| cause_o | output | 16 | Latched reset-cause code |

## Verification
The bench builds the block with reset values of 20 for the count, 3 for the scaler and 5 for the grace value. With these values the first interrupt is due at clock 84 after reset and the reset request at clock 108, so the behaviour straight out of reset is checked to the exact cycle. Software then programs scalers of 0, 1 and 2. These bring several cases within a few hundred cycles:
- a tick on every clock, where the interrupt and the reset request fall back to back;
- rewrites that land on every prescaler phase, including the clock of a tick;
- trap-door writes made in each state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      WD_INIT = 2'd0,
      WD_OFF  = 2'd1,
      WD_RUN  = 2'd2,
      WD_HALT = 2'd3
   } wd_state_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int SCL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             hold,
   input  logic [SCL_W-1:0] limit,
   output logic             tick
);
   logic [SCL_W-1:0] phase;

   assign tick = !hold && !restart && (phase == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase <= '0;
      else if (restart)    phase <= '0;
      else if (!hold)      phase <= tick ? '0 : phase + 1'b1;
   end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
#(
   parameter int          CNT_W      = 16,
   parameter int          SCL_W      = 8,
   parameter int          DLY_W      = 8,
   parameter int          CAUSE_W    = 16,
   parameter logic [CAUSE_W-1:0] CAUSE_CODE = 16'hC000,
   parameter int          RST_COUNT  = 16'hFFFF,
   parameter int          RST_SCALER = 255,
   parameter int          RST_DELAY  = 255
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_we,
   input  logic               trap_we,
   input  logic [CNT_W-1:0]   new_cnt,
   input  logic [SCL_W-1:0]   new_scl,
   input  logic [DLY_W-1:0]   new_dly,
   input  logic               tick,
   output logic [SCL_W-1:0]   scaler,
   output wd_state_e          state,
   output logic               irq,
   output logic               rst_req,
   output logic [CAUSE_W-1:0] cause
);
   logic [CNT_W-1:0] count;
   logic [DLY_W-1:0] grace;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scaler  <= SCL_W'(RST_SCALER);
         count   <= CNT_W'(RST_COUNT);
         grace   <= DLY_W'(RST_DELAY);
         armed   <= 1'b0;
         state   <= WD_INIT;
         irq     <= 1'b0;
         rst_req <= 1'b0;
         cause   <= '0;
      end else begin
         irq     <= 1'b0;
         rst_req <= 1'b0;
         if (prog_we) begin
            scaler <= new_scl;
            count  <= new_cnt;
            grace  <= new_dly;
            armed  <= 1'b0;
            state  <= WD_RUN;
         end else begin
            if (trap_we && state == WD_INIT)
               state <= WD_OFF;
            if (tick) begin
               unique case (state)
                  WD_OFF: state <= WD_HALT;
                  WD_INIT, WD_RUN: begin
                     if (count != '0) begin
                        count <= count - 1'b1;
                     end else if (armed) begin
                        rst_req <= 1'b1;
                        cause   <= CAUSE_CODE;
                        state   <= WD_HALT;
                     end else begin
                        irq   <= 1'b1;
                        armed <= 1'b1;
                        count <= CNT_W'(grace);
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
   import wdt_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int SCL_W      = 8,
   parameter int DLY_W      = 8,
   parameter int CAUSE_W    = 16,
   parameter logic [CAUSE_W-1:0] CAUSE_CODE = 16'hC000,
   parameter int RST_COUNT  = 16'hFFFF,
   parameter int RST_SCALER = 255,
   parameter int RST_DELAY  = 255
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               irq_o,
   output logic               rst_req_o,
   output logic [CAUSE_W-1:0] cause_o
);
   localparam int SCL_LSB = CNT_W;
   localparam int DLY_LSB = CNT_W + SCL_W;
   localparam int USED_W  = CNT_W + SCL_W + DLY_W;

   if (USED_W > DATA_W) begin : g_bad_fields
      $error("wdt_two_stage: fields need %0d bits, data word has %0d", USED_W, DATA_W);
   end
   if (SCL_W < 1 || CNT_W < 1 || DLY_W < 1) begin : g_bad_width
      $error("wdt_two_stage: every field needs at least one bit");
   end
   if (DLY_W > CNT_W) begin : g_bad_grace
      $error("wdt_two_stage: grace field wider than count");
   end

   logic             prog_we, trap_we, tick;
   logic [SCL_W-1:0] scaler;
   wd_state_e        st;

   assign prog_we = wr_en && !wr_sel;
   assign trap_we = wr_en &&  wr_sel;

   wdt_prescale #(.SCL_W(SCL_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (prog_we),
      .hold    (st == WD_HALT),
      .limit   (scaler),
      .tick    (tick)
   );

   wdt_core #(
      .CNT_W(CNT_W), .SCL_W(SCL_W), .DLY_W(DLY_W), .CAUSE_W(CAUSE_W),
      .CAUSE_CODE(CAUSE_CODE), .RST_COUNT(RST_COUNT),
      .RST_SCALER(RST_SCALER), .RST_DELAY(RST_DELAY)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .prog_we (prog_we),
      .trap_we (trap_we),
      .new_cnt (wr_data[CNT_W-1:0]),
      .new_scl (wr_data[SCL_LSB +: SCL_W]),
      .new_dly (wr_data[DLY_LSB +: DLY_W]),
      .tick    (tick),
      .scaler  (scaler),
      .state   (st),
      .irq     (irq_o),
      .rst_req (rst_req_o),
      .cause   (cause_o)
   );
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk
   import wdt_pkg::*;
#(
   parameter int CAUSE_W = 16,
   parameter logic [CAUSE_W-1:0] CAUSE_CODE = 16'hC000
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               wr_sel,
   input logic               irq_o,
   input logic               rst_req_o,
   input logic [CAUSE_W-1:0] cause_o,
   input wd_state_e          state
);
   assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);
   assert_cause_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> cause_o == CAUSE_CODE);
   assert_cause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_o != '0) |=> $stable(cause_o));
   assert_prog_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> state == WD_RUN);
   assert_trap_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && state == WD_RUN) |=> state != WD_OFF);
   assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_HALT && !(wr_en && !wr_sel)) |=> (!irq_o && !rst_req_o));
   assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_o && rst_req_o));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CAUSE_W(CAUSE_W), .CAUSE_CODE(CAUSE_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .irq_o(irq_o), .rst_req_o(rst_req_o), .cause_o(cause_o), .state(st)
);

// File: tb/wdt_two_stage_bench.sv
module wdt_two_stage_bench;
   localparam int R_CNT = 20, R_SCL = 3, R_DLY = 5;

   logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        irq_o, rst_req_o;
   logic [15:0] cause_o;

   always #5 clk = ~clk;

   wdt_two_stage #(.RST_COUNT(R_CNT), .RST_SCALER(R_SCL), .RST_DELAY(R_DLY)) u_wdt_two_stage (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .irq_o(irq_o), .rst_req_o(rst_req_o), .cause_o(cause_o)
   );

   int checks = 0, fails = 0;
   string tag = "R1";

   // reference model: 0 fresh, 1 off, 2 running, 3 halted
   int m_st, m_ph, m_scl, m_cnt, m_dly, m_irq, m_rq, m_cause;
   bit m_armed;
   int cyc = 0, first_irq = 0, first_rq = 0, irq_seen = 0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_ph = 0; m_scl = R_SCL; m_cnt = R_CNT; m_dly = R_DLY;
         m_armed = 0; m_irq = 0; m_rq = 0; m_cause = 0; cyc = 0;
      end else begin
         int old;
         bit tk;
         cyc++;
         m_irq = 0; m_rq = 0;
         if (wr_en && !wr_sel) begin
            m_cnt = wr_data[15:0]; m_scl = wr_data[23:16]; m_dly = wr_data[31:24];
            m_armed = 0; m_st = 2; m_ph = 0;
         end else begin
            old = m_st;
            tk = (old != 3) && (m_ph == m_scl);
            if (old != 3) m_ph = tk ? 0 : m_ph + 1;
            if (wr_en && wr_sel && old == 0) m_st = 1;
            if (tk) begin
               if (old == 1) m_st = 3;
               else if (old == 0 || old == 2) begin
                  if (m_cnt != 0) m_cnt--;
                  else if (m_armed) begin m_rq = 1; m_cause = 'hC000; m_st = 3; end
                  else begin m_irq = 1; m_armed = 1; m_cnt = m_dly; end
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk({tag, "/R4 irq"}, irq_o, m_irq);
         chk({tag, "/R5 rst_req"}, rst_req_o, m_rq);
         chk({tag, "/R6 cause"}, cause_o, m_cause);
         if (irq_o) begin irq_seen++; if (first_irq == 0) first_irq = cyc; end
         if (rst_req_o && first_rq == 0) first_rq = cyc;
      end
   end

   task automatic idle(int n); repeat (n) @(negedge clk); endtask
   task automatic wr(bit sel, logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask
   task automatic do_reset;
      @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1;
   endtask
   function automatic logic [31:0] word(int d, int s, int c);
      return {8'(d), 8'(s), 16'(c)};
   endfunction

   initial begin
      bit done = 0;
      fork
         begin
            tag = "R1"; idle(2); rst_n = 1'b1;
            #1; chk("R1 irq at reset", irq_o, 0); chk("R1 rst_req at reset", rst_req_o, 0);
            chk("R1 cause at reset", cause_o, 0);
            idle(120);
            chk("R3 first irq cycle", first_irq, (R_CNT + 1) * (R_SCL + 1));
            chk("R5 first reset request cycle", first_rq, (R_CNT + 1) * (R_SCL + 1) + (R_DLY + 1) * (R_SCL + 1));
            tag = "R8"; wr(1, 0); idle(40);                 // late trap door ignored, halted stays quiet
            chk("R6 cause kept", cause_o, 'hC000);
            tag = "R2"; irq_seen = 0;
            wr(0, word(2, 1, 4)); idle(11);                 // R2 field layout, R7 restart from halt
            chk("R2 irq after reprogram", irq_seen, 1);
            tag = "R7"; wr(0, word(2, 1, 4)); idle(11);   // clears arming: irq again, not reset
            chk("R7 second irq after rewrite", irq_seen, 2);
            idle(30);
            tag = "R6"; do_reset; #1; chk("R6 cause cleared by reset", cause_o, 0);
            tag = "R8"; wr(1, 0); irq_seen = 0; idle(200);  // R9 off then halted
            chk("R9 no irq while switched off", irq_seen, 0);
            tag = "R7"; wr(0, word(1, 0, 3)); idle(20);
            chk("R7 restart after switch-off", irq_seen >= 1, 1);
            tag = "R8"; wr(0, word(3, 0, 6)); wr(1, 0); irq_seen = 0; idle(20);
            chk("R8 trap door ignored while running", irq_seen >= 1, 1);
            tag = "R4"; wr(0, word(0, 0, 0)); idle(6);     // scaler 0: back-to-back stages, R10
            for (int ph = 0; ph < 8; ph++) begin
               tag = "R3"; wr(0, word(1, 2, 3)); idle(ph);
               wr(0, word(2, 2, 1)); idle(ph + 3);
            end
            idle(40);
            done = 1;
         end
         begin
            repeat (100000) @(negedge clk);
            if (!done) begin checks++; fails++; $display("FAIL watchdog: actual hung expected done"); end
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule